// File: doc/BRIEF.md
# PWM Duty-Cycle to Binary Converter

This block turns a pulse-width-modulated logic signal into an unsigned binary code proportional to its duty cycle. The PWM input arrives asynchronously. It is resynchronized to a fast sample clock. Two saturating counters then measure, in sample-clock cycles, the time the input spent high and the full span between consecutive rising edges. Each rising edge closes one measurement. If that measurement is usable, a restoring divider forms `code = floor(high * 2^CODE_W / period)`. The block then presents the result with a one-cycle update strobe.

Updates are event driven and happen once per PWM period. There is no averaging and no filtering. Each update follows the rising edge that ends the measured period by a fixed number of clock cycles.

Several kinds of edge produce no update:
- the first edge after reset, or after a timeout, because no whole period exists yet;
- an edge that ends a period shorter than the computation window;
- an edge that ends a period so long that the period counter saturated.

A saturated period also raises a flag that downstream idle logic can use. Pulses shorter than a minimum width are forced to the code extremes rather than divided.

Top module: `pwm_duty_conv`

## Requirements
- R1: While reset is asserted and after its release with no input activity, `codeOut` is 0, `updStrobe` is 0 and `longFlag` is 0.
- R2: For a period of P clock cycles whose high part lasts H cycles, with neither part narrow, the published code is floor(H * 2^CODE_W / P).
- R3: The update appears exactly CODE_W+3 clock edges after the clock edge that first samples the rising input level.
- R4: The rising edge that follows reset produces no update, because no complete period precedes it.
- R5: A period shorter than MIN_PERIOD_CYC cycles (raised to CODE_W+2 if smaller) produces no update. The previously published code is kept.
- R6: A high time shorter than MIN_PULSE_CYC cycles yields code 0, whatever the period.
- R7: A low time shorter than MIN_PULSE_CYC cycles yields the full-scale code 2^CODE_W − 1. A duty of 100 % saturates to that same value.
- R8: When the time since the last rising edge reaches 2^CNT_W − 1 cycles, `longFlag` rises and stays high until the next rising edge. That edge produces no update, and the period after it is converted normally.
- R9: `updStrobe` is high for exactly one cycle per update, and `codeOut` changes only in the cycle in which `updStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | Asynchronous PWM input |
| codeOut | output | CODE_W | Most recent duty-cycle code |
| updStrobe | output | 1 | One-cycle pulse when `codeOut` takes a new value |
| longFlag | output | 1 | Period counter saturated (input idle too long) |

## Verification
The bench builds the block with CODE_W = 8, CNT_W = 12, MIN_PERIOD_CYC = 20 and MIN_PULSE_CYC = 5. At these values the saturation limit is 4095 cycles, so idle timeouts with the input held low and with it held high take only a few thousand cycles each. The short-period boundary sits at 19 and 20 cycles, and the narrow-pulse cut-offs at 4 and 5 cycles. With periods of a few tens of cycles, an update lands every couple of hundred nanoseconds. This makes room for a long pseudo-random train of duty ratios next to the hand-picked corner cases, and each result is checked both for its code value and for its exact arrival cycle.

// File: rtl/pwm_conv_pkg.sv
package pwm_conv_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic restart;  // rising edge seen: close measurement, restart counters
    logic load;     // accepted edge: load divider operands
    logic step;     // one restoring-division iteration
    logic finish;   // publish quotient and pulse the update strobe
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } convState_t;
endpackage

// File: rtl/pwm_conv_sync.sv
module pwm_conv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [STAGES-1:0] stageQ;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b0;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/pwm_conv_ctrl.sv
module pwm_conv_ctrl
  import pwm_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmSync,
  input  logic        perShort,
  input  logic        perSat,
  output ctrlStrobe_t strobes
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IW-1:0] LAST_ITER = IW'(CODE_W - 1);

  logic       prevLvl;
  logic       rise;
  logic       armed;
  logic       accept;
  logic [IW-1:0] iterQ;
  convState_t state;

  assign rise   = pwmSync & ~prevLvl;
  assign accept = rise & armed & ~perShort & ~perSat & (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= pwmSync;
  end

  // An edge arms the converter; a saturated period disarms it so the
  // next edge only reopens measurement.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armed <= 1'b0;
    else if (rise)   armed <= 1'b1;
    else if (perSat) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iterQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          iterQ <= '0;
          if (accept) state <= ST_DIV;
        end
        ST_DIV: begin
          iterQ <= iterQ + 1'b1;
          if (iterQ == LAST_ITER) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.restart = rise;
    strobes.load    = accept;
    strobes.step    = (state == ST_DIV);
    strobes.finish  = (state == ST_FIN);
  end
endmodule

// File: rtl/pwm_conv_dp.sv
module pwm_conv_dp
  import pwm_conv_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int CNT_W          = 12,
  parameter int MIN_PERIOD_CYC = 20,
  parameter int MIN_PULSE_CYC  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmSync,
  input  ctrlStrobe_t       strobes,
  output logic              perShort,
  output logic              perSat,
  output logic [CODE_W-1:0] codeOut,
  output logic              updStrobe
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  PER_MIN   = CNT_W'(MIN_PERIOD_CYC);
  localparam logic [CNT_W-1:0]  PULSE_MIN = CNT_W'(MIN_PULSE_CYC);
  localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};

  logic [CNT_W-1:0]  perCnt, hiCnt;
  logic [CNT_W-1:0]  lowTime;
  logic [CNT_W:0]    remQ;
  logic [CNT_W-1:0]  divQ;
  logic [CODE_W-1:0] quoQ;
  logic              forceZero, forceFull;
  logic [CNT_W:0]    remShift;
  logic              remFits;

  assign perSat   = (perCnt == CNT_MAX);
  assign perShort = (perCnt < PER_MIN);
  assign lowTime  = perCnt - hiCnt;

  // Saturating period and high-time counters, restarted on each rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
      hiCnt  <= '0;
    end else if (strobes.restart) begin
      perCnt <= CNT_W'(1);
      hiCnt  <= CNT_W'(1);
    end else begin
      if (perCnt != CNT_MAX) perCnt <= perCnt + 1'b1;
      if (pwmSync && hiCnt != CNT_MAX) hiCnt <= hiCnt + 1'b1;
    end
  end

  assign remShift = {remQ[CNT_W-1:0], 1'b0};
  assign remFits  = (remShift >= {1'b0, divQ});

  // Restoring divider: CODE_W iterations of shift / compare / subtract
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ      <= '0;
      divQ      <= '0;
      quoQ      <= '0;
      forceZero <= 1'b0;
      forceFull <= 1'b0;
    end else if (strobes.load) begin
      remQ      <= {1'b0, hiCnt};
      divQ      <= perCnt;
      quoQ      <= '0;
      forceZero <= (hiCnt < PULSE_MIN);
      forceFull <= (lowTime < PULSE_MIN) || (hiCnt >= perCnt);
    end else if (strobes.step) begin
      if (remFits) begin
        remQ <= remShift - {1'b0, divQ};
        quoQ <= {quoQ[CODE_W-2:0], 1'b1};
      end else begin
        remQ <= remShift;
        quoQ <= {quoQ[CODE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut   <= '0;
      updStrobe <= 1'b0;
    end else begin
      updStrobe <= strobes.finish;
      if (strobes.finish) begin
        if (forceZero)      codeOut <= '0;
        else if (forceFull) codeOut <= CODE_FULL;
        else                codeOut <= quoQ;
      end
    end
  end
endmodule

// File: rtl/pwm_duty_conv.sv
module pwm_duty_conv
  import pwm_conv_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int CNT_W          = 12,
  parameter int MIN_PERIOD_CYC = 20,
  parameter int MIN_PULSE_CYC  = 5,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              updStrobe,
  output logic              longFlag
);
  timeunit 1ns;
  timeprecision 100ps;

  // The divider must finish before the next accepted edge
  localparam int MIN_PER_EFF = (MIN_PERIOD_CYC > CODE_W + 2) ? MIN_PERIOD_CYC : CODE_W + 2;

  logic        pwmSync;
  logic        perShort;
  logic        perSat;
  ctrlStrobe_t strobes;

  pwm_conv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pwmIn),
    .syncOut (pwmSync)
  );

  pwm_conv_ctrl #(.CODE_W(CODE_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pwmSync  (pwmSync),
    .perShort (perShort),
    .perSat   (perSat),
    .strobes  (strobes)
  );

  pwm_conv_dp #(
    .CODE_W         (CODE_W),
    .CNT_W          (CNT_W),
    .MIN_PERIOD_CYC (MIN_PER_EFF),
    .MIN_PULSE_CYC  (MIN_PULSE_CYC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwmSync   (pwmSync),
    .strobes   (strobes),
    .perShort  (perShort),
    .perSat    (perSat),
    .codeOut   (codeOut),
    .updStrobe (updStrobe)
  );

  assign longFlag = perSat;
endmodule

// File: rtl/pwm_duty_conv_chk.sv
module pwm_duty_conv_chk
  import pwm_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input ctrlStrobe_t       strobes,
  input logic              perShort,
  input logic              perSat,
  input logic [CODE_W-1:0] codeOut,
  input logic              updStrobe,
  input logic              longFlag
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LW = $clog2(CODE_W + 4) + 1;
  localparam logic [LW-1:0] LAT_EXP = LW'(CODE_W + 2);

  logic [LW-1:0] latCnt;
  logic          seenRise;

  // Cycles since the last accepted load, stopped once the update appears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             latCnt <= '0;
    else if (strobes.load)                 latCnt <= LW'(1);
    else if (updStrobe)                    latCnt <= '0;
    else if (latCnt != '0 && latCnt != '1) latCnt <= latCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               seenRise <= 1'b0;
    else if (strobes.restart) seenRise <= 1'b1;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe);

  a_r9_code_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeOut) |-> updStrobe);

  a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> (latCnt == LAT_EXP));

  a_r4_first_edge_ignored: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> seenRise);

  a_r5_no_load_short: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !perShort);

  a_r8_no_load_saturated: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !perSat);

  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (longFlag && !strobes.restart) |=> longFlag);
endmodule

bind pwm_duty_conv pwm_duty_conv_chk #(.CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .strobes   (strobes),
  .perShort  (perShort),
  .perSat    (perSat),
  .codeOut   (codeOut),
  .updStrobe (updStrobe),
  .longFlag  (longFlag)
);

// File: tb/pwm_duty_conv_tb_top.sv
module pwm_duty_conv_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CODE_W   = 8;
  localparam int CNT_W    = 12;
  localparam int MIN_PER  = 20;
  localparam int MIN_PUL  = 5;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int FULL     = (1 << CODE_W) - 1;
  localparam int LATENCY  = CODE_W + 4;

  typedef struct {
    int     code;
    longint due;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pwmIn = 1'b0;
  logic [CODE_W-1:0] codeOut;
  logic              updStrobe;
  logic              longFlag;

  int       vecs = 0;
  int       fails = 0;
  longint   cycCnt = 0;
  expItem_t expQ[$];
  int       prevH = 0;
  int       prevP = 0;
  bit       armedM = 1'b0;
  int       lastExp = 0;
  bit       done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  pwm_duty_conv #(
    .CODE_W         (CODE_W),
    .CNT_W          (CNT_W),
    .MIN_PERIOD_CYC (MIN_PER),
    .MIN_PULSE_CYC  (MIN_PUL),
    .SYNC_STAGES    (2)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwmIn     (pwmIn),
    .codeOut   (codeOut),
    .updStrobe (updStrobe),
    .longFlag  (longFlag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected code from the requirements (R2, R6, R7)
  function automatic int expCode(input int h, input int p);
    if (h < MIN_PUL)          return 0;          // R6
    else if (p - h < MIN_PUL) return FULL;       // R7
    else                      return (h << CODE_W) / p;  // R2
  endfunction

  // Called at the negedge where the input rises: this edge ends the last period
  task automatic onRise();
    expItem_t it;
    if (armedM && prevP >= MIN_PER && prevP < CNT_MAX) begin
      it.code = expCode(prevH, prevP);
      it.due  = cycCnt + LATENCY;   // R3
      expQ.push_back(it);
      lastExp = it.code;
    end
    armedM = 1'b1;                  // R4 / R8: unarmed edges only reopen
  endtask

  task automatic pulse(input int h, input int l);
    pwmIn = 1'b1;
    onRise();
    repeat (h) @(negedge clk);
    pwmIn = 1'b0;
    repeat (l) @(negedge clk);
    prevH = h;
    prevP = h + l;
  endtask

  task automatic idleLow(input int n);
    repeat (n) @(negedge clk);
    prevP += n;
  endtask

  // Monitor: scoreboard comparison of every update
  always @(negedge clk) begin
    if (rstN && !done && updStrobe) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected update", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check("R2 code", longint'(codeOut), longint'(it.code));
        check("R3 latency", cycCnt, it.due);
      end
    end
  end

  initial begin
    int unsigned lfsr;
    lfsr = 32'h1D2C_3A5B;
    repeat (4) @(negedge clk);
    check("R1 codeOut", codeOut, 0);
    check("R1 updStrobe", updStrobe, 0);
    check("R1 longFlag", longFlag, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle after release", {longFlag, updStrobe, codeOut}, 0);

    pulse(10, 30);   // R4: first edge yields nothing
    pulse(20, 20);   // closes 10/40 -> 64
    pulse(1, 39);    // closes 20/40 -> 128
    pulse(37, 3);    // closes 1/40 -> R6 zero
    pulse(4, 36);    // closes 37/40 -> R7 full
    pulse(5, 35);    // closes 4/40 -> R6 zero
    pulse(35, 5);    // closes 5/40 -> 32
    pulse(36, 4);    // closes 35/40 -> 224
    pulse(10, 9);    // closes 36/40 -> R7 full
    pulse(10, 10);   // closes 19-cycle period -> R5 skipped
    pulse(7, 13);    // closes 20-cycle period -> 128
    check("R5 held code after skip", codeOut, lastExp);

    for (int i = 0; i < 60; i++) begin
      int h, l;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      h = 1 + int'(lfsr % 70);
      l = 1 + int'((lfsr >> 8) % 70);
      pulse(h, l);
    end

    pulse(15, 25);
    idleLow(4200);
    check("R8 flag after low idle", longFlag, 1);
    pulse(12, 28);   // R8: this edge closes a saturated period -> skipped
    check("R8 flag cleared by edge", longFlag, 0);
    pulse(30, 10);   // R8: closes 12/40 -> normal conversion
    pulse(8, 4300);  // long low again
    pulse(4300, 20); // edge after saturation, then long high
    check("R8 flag after high idle", longFlag, 1);
    pulse(10, 30);   // skipped, re-arms
    pulse(25, 15);   // closes 10/40 -> 64
    pulse(10, 30);   // closes 25/40 -> 160
    repeat (40) @(negedge clk);

    check("R9 all updates seen", expQ.size(), 0);
    check("R5 final code held", codeOut, lastExp);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycCnt, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule